// File: doc/BRIEF.md
# Prioritized Level-Sensitive Interrupt Controller

This block collects 64 level-sensitive interrupt sources, masks them with a per-source enable, and picks the pending source with the highest 4-bit priority. It presents the result to a processor as a request line, the winning level and the winning source index. Software configures it over a small register bus that has an address, write data, a write strobe, a read strobe and read data.

The enable mask is never written directly. Each 32-bit bank has one address where ones set enable bits and another address where ones clear them, so software can change single sources without a read-modify-write. A one-bit mode flag is changed the same way, through its own set and clear addresses.

Priorities sit in eight packed registers of eight 4-bit fields each. A priority of zero keeps a source silent. Read-only views return the raw source levels and the masked pending requests. The arbitration result is registered and is recomputed on every clock.

Top module: `irqc_top`

## Requirements
- R1: After reset the enable mask, every priority field and the mode flag are 0. `irq_req`, `irq_lvl`, `irq_idx`, `ctrl_mode` and `rd_data` are all 0.
- R2: A write to 0x70 (bank 0) or 0x78 (bank 1) sets each enable bit whose data bit is 1 and leaves the other bits alone. Source n maps to bit n of bank 0 when n < 32, and to bit n-32 of bank 1 otherwise. Reading 0x70 or 0x78 returns that bank's enable mask.
- R3: A write to 0x80 (bank 0) or 0x88 (bank 1) clears each enable bit whose data bit is 1 and leaves the other bits alone. Writing all ones masks the whole bank. Reads of these addresses return 0.
- R4: Priority register k (k = 0..7) is at 0x10 + 8k. It is fully writable and reads back its contents. Source i takes its priority from bits [(i mod 8)*4 +: 4] of register i/8.
- R5: Reading 0x50 or 0x58 returns the raw source levels of bank 0 or bank 1. Reading 0x60 or 0x68 returns the raw levels ANDed with the enables of that bank. Writes to these four addresses change no state.
- R6: A source whose priority is 0 never raises `irq_req` and is never selected, even when it is enabled and asserted.
- R7: The selected source is the enabled, asserted source with the largest priority. Among equal priorities the lowest index wins. `irq_lvl` and `irq_idx` show the selection computed from the state and the inputs at the previous clock edge.
- R8: `irq_req` is 1 exactly when some enabled, asserted source has a nonzero priority. While it is 0, `irq_lvl` and `irq_idx` are 0.
- R9: Writing data with bit 0 set to 0x00 sets the mode flag. Writing data with bit 0 set to 0x08 clears it. A write with bit 0 clear to either address leaves the flag unchanged. Reading 0x00 returns the flag in bit 0, reading 0x08 returns 0, and `ctrl_mode` shows the flag.
- R10: `rd_data` loads on a clock edge where `rd_en` is 1 and holds at other times. Addresses that do not match a register, including ones whose low three bits are not zero, read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 8 | Register byte address |
| wr_data | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| rd_en | input | 1 | Read strobe, `rd_data` updates on that edge |
| rd_data | output | 32 | Registered read data |
| src | input | 64 | Level-sensitive interrupt sources |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_lvl | output | 4 | Priority of the selected source |
| irq_idx | output | 6 | Index of the selected source |
| ctrl_mode | output | 1 | Mode flag from the control register |

## Verification
The assertions assume that `src`, `addr`, `wr_data` and both strobes are synchronous to `clk` and settle before each rising edge. They also assume that a write presents its data in the same cycle as its strobe, because the set and clear properties relate the enable bank to the data word sampled at that edge. The bench meets these conditions by changing every input only on the falling edge. Each write strobe lasts exactly one cycle, and reads are never issued in the same cycle as a write.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  // Register word decode: byte address = word index * 8
  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CTRL_SET,
    SEL_CTRL_CLR,
    SEL_PRIO,
    SEL_STAT,
    SEL_PEND,
    SEL_EN_SET,
    SEL_EN_CLR
  } reg_sel_e;

  typedef struct packed {
    reg_sel_e   sel;
    logic [2:0] idx;   // bank number or priority register number
  } reg_dec_t;

  localparam logic [4:0] W_CTRL_SET = 5'd0;
  localparam logic [4:0] W_CTRL_CLR = 5'd1;
  localparam logic [4:0] W_PRIO_LO  = 5'd2;
  localparam logic [4:0] W_PRIO_HI  = 5'd9;
  localparam logic [4:0] W_STAT     = 5'd10;
  localparam logic [4:0] W_PEND     = 5'd12;
  localparam logic [4:0] W_EN_SET   = 5'd14;
  localparam logic [4:0] W_EN_CLR   = 5'd16;

  function automatic reg_dec_t decode_addr(input logic [7:0] a);
    reg_dec_t   d;
    logic [4:0] w;
    d.sel = SEL_NONE;
    d.idx = '0;
    w     = a[7:3];
    if (a[2:0] == 3'b000) begin
      if (w == W_CTRL_SET) begin
        d.sel = SEL_CTRL_SET;
      end else if (w == W_CTRL_CLR) begin
        d.sel = SEL_CTRL_CLR;
      end else if (w >= W_PRIO_LO && w <= W_PRIO_HI) begin
        d.sel = SEL_PRIO;
        d.idx = 3'(w - W_PRIO_LO);
      end else if (w[4:1] == W_STAT[4:1]) begin
        d.sel = SEL_STAT;
        d.idx = {2'b00, w[0]};
      end else if (w[4:1] == W_PEND[4:1]) begin
        d.sel = SEL_PEND;
        d.idx = {2'b00, w[0]};
      end else if (w[4:1] == W_EN_SET[4:1]) begin
        d.sel = SEL_EN_SET;
        d.idx = {2'b00, w[0]};
      end else if (w[4:1] == W_EN_CLR[4:1]) begin
        d.sel = SEL_EN_CLR;
        d.idx = {2'b00, w[0]};
      end
    end
    return d;
  endfunction

endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/irqc_regfile.sv
module irqc_regfile
  import irqc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned DATA_W  = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [7:0]                addr,
  input  logic [DATA_W-1:0]         wr_data,
  input  logic                      wr_en,
  input  logic                      rd_en,
  output logic [DATA_W-1:0]         rd_data,
  input  logic [NUM_SRC-1:0]        src,
  output logic [NUM_SRC-1:0]        en_mask,
  output logic [NUM_SRC*PRIO_W-1:0] prio_vec,
  output logic                      mode
);

  localparam int unsigned NUM_BANKS     = NUM_SRC / DATA_W;
  localparam int unsigned FLD_PER_REG   = DATA_W / PRIO_W;
  localparam int unsigned NUM_PRIO_REGS = NUM_SRC / FLD_PER_REG;

  reg_dec_t dec;
  assign dec = decode_addr(addr);

  // ---------------- enable banks ----------------
  logic [DATA_W-1:0] en_q   [NUM_BANKS];
  logic [DATA_W-1:0] en_d   [NUM_BANKS];
  logic [NUM_BANKS-1:0] set_hit, clr_hit, en_we;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign set_hit[b] = wr_en && (dec.sel == SEL_EN_SET) && (dec.idx == 3'(b));
    assign clr_hit[b] = wr_en && (dec.sel == SEL_EN_CLR) && (dec.idx == 3'(b));
    assign en_we[b]   = set_hit[b] | clr_hit[b];

    always_comb begin
      if (set_hit[b]) begin
        en_d[b] = en_q[b] | wr_data;
      end else begin
        en_d[b] = en_q[b] & ~wr_data;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q[b] <= '0;
      end else if (en_we[b]) begin
        en_q[b] <= en_d[b];
      end
    end

    assign en_mask[b*DATA_W +: DATA_W] = en_q[b];

    AST_ENSET_SETS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      set_hit[b] |=> (((en_q[b] & $past(wr_data)) == $past(wr_data)) &&
                      (((en_q[b] ^ $past(en_q[b])) & ~$past(wr_data)) == '0))); // R2
    AST_ENCLR_CLEARS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit[b] |=> (((en_q[b] & $past(wr_data)) == '0) &&
                      (((en_q[b] ^ $past(en_q[b])) & ~$past(wr_data)) == '0))); // R3
    AST_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !en_we[b] |=> $stable(en_q[b])); // R5
  end

  // ---------------- priority registers ----------------
  logic [DATA_W-1:0]        prio_q [NUM_PRIO_REGS];
  logic [NUM_PRIO_REGS-1:0] prio_we;

  for (genvar k = 0; k < NUM_PRIO_REGS; k++) begin : g_prio
    assign prio_we[k] = wr_en && (dec.sel == SEL_PRIO) && (dec.idx == 3'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prio_q[k] <= '0;
      end else if (prio_we[k]) begin
        prio_q[k] <= wr_data;
      end
    end

    assign prio_vec[k*DATA_W +: DATA_W] = prio_q[k];
  end

  // ---------------- control flag ----------------
  logic mode_q, mode_d, mode_we;

  always_comb begin
    mode_we = 1'b0;
    mode_d  = mode_q;
    if (wr_en && wr_data[0]) begin
      if (dec.sel == SEL_CTRL_SET) begin
        mode_we = 1'b1;
        mode_d  = 1'b1;
      end else if (dec.sel == SEL_CTRL_CLR) begin
        mode_we = 1'b1;
        mode_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= 1'b0;
    end else if (mode_we) begin
      mode_q <= mode_d;
    end
  end

  assign mode = mode_q;

  AST_CTRL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0] && dec.sel == SEL_CTRL_SET) |=> mode_q); // R9
  AST_CTRL_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[0] && dec.sel == SEL_CTRL_CLR) |=> !mode_q); // R9

  // ---------------- read path ----------------
  logic [DATA_W-1:0] rd_d, rd_q;

  always_comb begin
    rd_d = '0;
    unique case (dec.sel)
      SEL_CTRL_SET: rd_d = {{(DATA_W-1){1'b0}}, mode_q};
      SEL_PRIO: begin
        for (int k = 0; k < NUM_PRIO_REGS; k++) begin
          if (dec.idx == 3'(k)) rd_d = prio_q[k];
        end
      end
      SEL_STAT: begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (dec.idx == 3'(b)) rd_d = src[b*DATA_W +: DATA_W];
        end
      end
      SEL_PEND: begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (dec.idx == 3'(b)) rd_d = src[b*DATA_W +: DATA_W] & en_q[b];
        end
      end
      SEL_EN_SET: begin
        for (int b = 0; b < NUM_BANKS; b++) begin
          if (dec.idx == 3'(b)) rd_d = en_q[b];
        end
      end
      default: rd_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_en) begin
      rd_q <= rd_d;
    end
  end

  assign rd_data = rd_q;

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_q)); // R10
  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (dec.sel == SEL_EN_CLR || dec.sel == SEL_CTRL_CLR)) |=> (rd_q == '0)); // R3

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        src,
  input  logic [NUM_SRC-1:0]        en_mask,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_vec,
  output logic                      irq_req,
  output logic [PRIO_W-1:0]         irq_lvl,
  output logic [IDX_W-1:0]          irq_idx
);

  logic [PRIO_W-1:0]  prio_f [NUM_SRC];
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] cand;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign prio_f[i]  = prio_vec[i*PRIO_W +: PRIO_W];
    assign pending[i] = src[i] & en_mask[i];
    assign cand[i]    = pending[i] & (|prio_f[i]);
  end

  // Next-state: scan in index order; strict compare keeps the lowest index on ties
  logic [PRIO_W-1:0] lvl_d;
  logic [IDX_W-1:0]  idx_d;
  logic              req_d;

  always_comb begin
    lvl_d = '0;
    idx_d = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (pending[i] && (prio_f[i] > lvl_d)) begin
        lvl_d = prio_f[i];
        idx_d = IDX_W'(i);
      end
    end
    req_d = |cand;
  end

  logic              req_q;
  logic [PRIO_W-1:0] lvl_q;
  logic [IDX_W-1:0]  idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= 1'b0;
      lvl_q <= '0;
      idx_q <= '0;
    end else begin
      req_q <= req_d;
      lvl_q <= lvl_d;
      idx_q <= idx_d;
    end
  end

  assign irq_req = req_q;
  assign irq_lvl = lvl_q;
  assign irq_idx = idx_q;

  AST_REQ_LVL_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req == (irq_lvl != '0)); // R8
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_idx == '0 && irq_lvl == '0)); // R8
  AST_NO_CAND_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cand == '0) |=> !irq_req); // R6
  AST_CAND_GIVES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (cand != '0) |=> irq_req); // R7

endmodule

// File: rtl/irqc_top.sv
module irqc_top #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned PRIO_W  = 4,
  parameter int unsigned DATA_W  = 32,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [7:0]         addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               wr_en,
  input  logic               rd_en,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [NUM_SRC-1:0] src,
  output logic               irq_req,
  output logic [PRIO_W-1:0]  irq_lvl,
  output logic [IDX_W-1:0]   irq_idx,
  output logic               ctrl_mode
);

  logic                      rst_int_n;
  logic [NUM_SRC-1:0]        en_mask;
  logic [NUM_SRC*PRIO_W-1:0] prio_vec;

  irqc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  irqc_regfile #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W),
    .DATA_W  (DATA_W)
  ) u_regfile (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .addr     (addr),
    .wr_data  (wr_data),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .src      (src),
    .en_mask  (en_mask),
    .prio_vec (prio_vec),
    .mode     (ctrl_mode)
  );

  irqc_arbiter #(
    .NUM_SRC (NUM_SRC),
    .PRIO_W  (PRIO_W)
  ) u_arbiter (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .src      (src),
    .en_mask  (en_mask),
    .prio_vec (prio_vec),
    .irq_req  (irq_req),
    .irq_lvl  (irq_lvl),
    .irq_idx  (irq_idx)
  );

endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  addr;
  logic [31:0] wr_data;
  logic        wr_en;
  logic        rd_en;
  logic [31:0] rd_data;
  logic [63:0] src;
  logic        irq_req;
  logic [3:0]  irq_lvl;
  logic [5:0]  irq_idx;
  logic        ctrl_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  irqc_top u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
    .rd_en(rd_en), .rd_data(rd_data), .src(src), .irq_req(irq_req),
    .irq_lvl(irq_lvl), .irq_idx(irq_idx), .ctrl_mode(ctrl_mode)
  );

  // reference state
  logic [63:0] m_en;
  logic [3:0]  m_prio [64];
  logic        m_mode;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [4:0]  w;
    logic [31:0] r;
    w = a[7:3];
    r = '0;
    if (a[2:0] == 3'b000) begin
      if (w == 5'd0) r = {31'b0, m_mode};
      else if (w >= 5'd2 && w <= 5'd9) begin
        for (int j = 0; j < 8; j++) r[j*4 +: 4] = m_prio[(int'(w) - 2)*8 + j];
      end
      else if (w == 5'd10) r = src[31:0];
      else if (w == 5'd11) r = src[63:32];
      else if (w == 5'd12) r = src[31:0] & m_en[31:0];
      else if (w == 5'd13) r = src[63:32] & m_en[63:32];
      else if (w == 5'd14) r = m_en[31:0];
      else if (w == 5'd15) r = m_en[63:32];
    end
    return r;
  endfunction

  // expected arbitration: {req, lvl, idx}
  function automatic logic [10:0] exp_arb();
    logic [3:0] bl;
    logic [5:0] bi;
    bl = '0;
    bi = '0;
    for (int i = 0; i < 64; i++) begin
      if (src[i] && m_en[i] && m_prio[i] > bl) begin
        bl = m_prio[i];
        bi = 6'(i);
      end
    end
    return {(bl != 0), bl, bi};
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    logic [4:0] w;
    w = a[7:3];
    if (a[2:0] != 3'b000) return;
    if (w == 5'd0 && d[0]) m_mode = 1'b1;
    else if (w == 5'd1 && d[0]) m_mode = 1'b0;
    else if (w >= 5'd2 && w <= 5'd9) begin
      for (int j = 0; j < 8; j++) m_prio[(int'(w) - 2)*8 + j] = d[j*4 +: 4];
    end
    else if (w == 5'd14) m_en[31:0]  = m_en[31:0]  | d;
    else if (w == 5'd15) m_en[63:32] = m_en[63:32] | d;
    else if (w == 5'd16) m_en[31:0]  = m_en[31:0]  & ~d;
    else if (w == 5'd17) m_en[63:32] = m_en[63:32] & ~d;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    model_write(a, d);
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic check_read(input string tag, input logic [7:0] a);
    logic [31:0] d;
    bus_read(a, d);
    chk(tag, d, exp_read(a));
  endtask

  task automatic check_arb(input string tag);
    logic [10:0] e;
    repeat (2) @(negedge clk);
    e = exp_arb();
    chk(tag, {21'b0, irq_req, irq_lvl, irq_idx}, {21'b0, e});
  endtask

  task automatic set_src(input logic [63:0] v);
    @(negedge clk);
    src = v;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd20240611));
    m_en = '0; m_mode = 1'b0;
    for (int i = 0; i < 64; i++) m_prio[i] = '0;
    addr = '0; wr_data = '0; wr_en = 1'b0; rd_en = 1'b0; src = '0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 outputs", {20'b0, irq_req, irq_lvl, irq_idx, ctrl_mode}, 32'd0);
    chk("R1 rd_data", rd_data, 32'd0);
    check_read("R1 enable bank1", 8'h78);
    check_read("R1 prio reg 7", 8'h48);

    // R9: control set/clear
    bus_write(8'h00, 32'h0000_0002);
    chk("R9 set without bit0", {31'b0, ctrl_mode}, 32'd0);
    bus_write(8'h00, 32'h0000_0001);
    chk("R9 mode set", {31'b0, ctrl_mode}, 32'd1);
    check_read("R9 read set addr", 8'h00);
    check_read("R9 read clr addr", 8'h08);
    bus_write(8'h08, 32'hFFFF_FFFF);
    chk("R9 mode clear", {31'b0, ctrl_mode}, 32'd0);

    // R4 / R7: tie and priority ordering
    bus_write(8'h10, 32'h0000_5050);   // src1 prio 5, src3 prio 5
    bus_write(8'h48, 32'h3000_0000);   // src63 prio 3
    bus_write(8'h70, 32'h0000_000A);
    bus_write(8'h78, 32'h8000_0000);
    check_read("R2 read enables bank0", 8'h70);
    set_src(64'h8000_0000_0000_000A);
    check_arb("R7 tie picks lowest index");
    bus_write(8'h48, 32'h9000_0000);
    check_arb("R7 bank1 higher priority wins");
    check_read("R4 prio readback", 8'h48);

    // R6: priority zero never requests
    bus_write(8'h80, 32'hFFFF_FFFF);
    bus_write(8'h88, 32'hFFFF_FFFF);
    check_arb("R3 all-ones clear masks all");
    check_read("R3 bank1 mask cleared", 8'h78);
    check_read("R3 clear addr reads zero", 8'h88);
    bus_write(8'h70, 32'h0000_0010);   // src4, prio 0
    set_src(64'h0000_0000_0000_0010);
    check_arb("R6 zero priority silent");
    check_read("R5 pending view", 8'h60);

    // R5 / R10: ignored writes, unmapped and misaligned addresses
    bus_write(8'h50, 32'hFFFF_FFFF);
    bus_write(8'h68, 32'hFFFF_FFFF);
    bus_write(8'h71, 32'hFFFF_FFFF);
    bus_write(8'hA0, 32'hFFFF_FFFF);
    check_read("R5 enables untouched by status write", 8'h70);
    check_read("R5 status view", 8'h50);
    check_read("R10 misaligned reads zero", 8'h71);
    check_read("R10 unmapped reads zero", 8'hF8);
    bus_read(8'h70, d);
    @(negedge clk);
    addr = 8'h58;
    @(negedge clk);
    chk("R10 rd_data holds", rd_data, 32'h0000_0010);

    // randomized mix
    for (int it = 0; it < 500; it++) begin
      int op;
      logic [31:0] rv;
      op = $urandom % 6;
      rv = $urandom;
      case (op)
        0: bus_write((($urandom % 2) == 0) ? 8'h70 : 8'h78, rv & $urandom);
        1: bus_write((($urandom % 2) == 0) ? 8'h80 : 8'h88, rv & $urandom & $urandom);
        2: bus_write(8'h10 + 8'(($urandom % 8) * 8), rv);
        3: bus_write((($urandom % 2) == 0) ? 8'h00 : 8'h08, rv);
        4: bus_write(8'h50 + 8'(($urandom % 4) * 8), rv);
        default: set_src({$urandom, $urandom} & {$urandom, $urandom});
      endcase
      check_arb("R7 random arbitration");
      chk("R9 random mode", {31'b0, ctrl_mode}, {31'b0, m_mode});
      check_read("R2 R4 R5 random read", 8'(($urandom % 20) * 8));
    end

    finish_run();
  end

endmodule